// File: doc/BRIEF.md
# Acquisition Run and Buffer Controller

This block decides when an acquisition run is live and keeps count of how many event blocks of the output memory currently hold data. A control write carries a run bit, a two-bit start mode, a full-policy bit and a trigger-counting bit. In the software mode the run follows the run bit alone. In the two level modes the run bit only arms acquisition, and the run lasts while a front input level is high. In the first-trigger mode the first rising edge of the trigger input opens the run but is not itself taken as a trigger.

The memory is split into 2^code equal blocks. Every event written takes one block. Every event read returns one block, and a release write of N returns N blocks at once. The block reports full, event-ready and an interrupt request that compares the stored count with a programmed level. Trigger edges are accepted only while running and not full. A counter tallies either the accepted triggers or every trigger edge seen during the run.

Top module: `acq_run_buf_ctrl`

## Requirements
- R1: After reset the run is off and the stored count, trigger count and release error are 0. Full, event-ready and interrupt are low.
- R2: Mode 00 (software): running equals the run bit. A control write that changes the run bit from 0 to 1 empties the stored count and the trigger count. Clearing the run bit stops the run and leaves the stored count unchanged.
- R3: Modes 01 (first level input) and 11 (second level input): running is high only while the run bit is 1 and the selected level input is 1.
- R4: Mode 10 (first trigger): once armed, the first rising edge of the trigger input starts the run and is not accepted. Later edges are accepted. Only a control write clearing the run bit ends the run.
- R5: A rising trigger edge while not running is never accepted and leaves the trigger count unchanged.
- R6: A buffer-code write sets the number of blocks to 2^code, with codes above 10 treated as 10. It also empties the stored count.
- R7: Full is asserted when the stored count reaches 2^code blocks, or 2^code-1 when the keep-one-free bit is set. An event write while full is dropped.
- R8: A release write of N frees N blocks. If the total to free in a cycle (release plus event read) exceeds the stored count, the stored count keeps only that cycle's accepted write and the sticky release error is set.
- R9: An event-read strobe frees one block. An accepted write in the same cycle adds one, so the net stored count is the sum of both.
- R10: Interrupt is high while the stored count is strictly greater than the 10-bit interrupt level. Event-ready is high while at least one event is stored.
- R11: A trigger edge while running and full is refused. With the count-all bit set, the trigger counter counts every edge seen while running. With it clear, the counter counts only accepted triggers.
- R12: A software clear empties the stored count, the trigger count and the release error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_run | input | 1 | Run bit carried by the control write |
| ctl_mode | input | 2 | Start mode carried by the control write |
| ctl_keep_free | input | 1 | Keep-one-block-free policy bit |
| ctl_count_all | input | 1 | Trigger counter counts every edge during the run |
| bcode_wr | input | 1 | Buffer-code write strobe |
| bcode | input | CODE_W | Buffer code (log2 of block count) |
| free_wr | input | 1 | Release write strobe |
| free_num | input | FREE_W | Number of blocks to release |
| sw_clear | input | 1 | Software clear strobe |
| irq_level | input | IRQ_W | Interrupt event level |
| sin_lvl | input | 1 | First level start input |
| gpio_lvl | input | 1 | Second level start input |
| trg_in | input | 1 | Trigger input; rising edges are triggers |
| evt_wr | input | 1 | One event written into a block |
| evt_rd | input | 1 | One event read out of a block |
| running | output | 1 | Run is live |
| trg_accept | output | 1 | Trigger edge accepted this cycle |
| full | output | 1 | Buffer full under the selected policy |
| evt_ready | output | 1 | At least one event is stored |
| irq | output | 1 | Stored count above interrupt level |
| free_err | output | 1 | Sticky over-release error |
| evt_stored | output | OCC_W | Blocks currently holding events |
| trg_count | output | TCNT_W | Trigger counter |

## Verification
The risky overlaps are an event write that lands in the same cycle as a release, and a trigger edge that coincides with the board becoming full or with the run opening. The bench drives the first case directly with a write, a read and an over-size release in one cycle. It also randomizes all strobes together. A bench model compares the stored count, error and full flag every cycle. For the second case, the bench places trigger edges on the arming edge in first-trigger mode and while full. It checks in the same cycle that acceptance is withheld, and checks after the edge that the counter moved according to the count-all bit.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [1:0] {
    START_SW   = 2'b00,
    START_SIN  = 2'b01,
    START_TRIG = 2'b10,
    START_GPIO = 2'b11
  } start_mode_e;

  // number of memory blocks for a buffer code, clamped at max_code
  function automatic int unsigned blocks_of(input int unsigned code,
                                            input int unsigned max_code);
    int unsigned c;
    c = (code > max_code) ? max_code : code;
    return 32'd1 << c;
  endfunction

  // occupancy at which the buffer reports full
  function automatic int unsigned full_limit(input int unsigned blocks,
                                             input logic keep_one);
    return keep_one ? blocks - 1 : blocks;
  endfunction

  // run qualification per start mode
  function automatic logic run_gate(input start_mode_e mode, input logic armed,
                                    input logic sin, input logic gpio,
                                    input logic started);
    logic g;
    case (mode)
      START_SW:   g = 1'b1;
      START_SIN:  g = sin;
      START_TRIG: g = started;
      default:    g = gpio;
    endcase
    return armed & g;
  endfunction

endpackage

// File: rtl/acq_run_ctrl.sv
module acq_run_ctrl
  import acq_pkg::*;
#(
  parameter int TCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_run,
  input  logic [1:0]        ctl_mode,
  input  logic              ctl_count_all,
  input  logic              sin_lvl,
  input  logic              gpio_lvl,
  input  logic              trg_in,
  input  logic              full,
  input  logic              clear,
  output logic              running,
  output logic              trg_edge,
  output logic              trg_accept,
  output logic              run_start,
  output logic [TCNT_W-1:0] tcnt
);

  logic        armed_q, started_q, trg_q, count_all_q;
  start_mode_e mode_q;
  logic        count_hit;

  assign trg_edge   = trg_in & ~trg_q;
  assign running    = run_gate(mode_q, armed_q, sin_lvl, gpio_lvl, started_q);
  assign trg_accept = running & trg_edge & ~full;
  assign run_start  = ctl_wr & ctl_run & ~armed_q;
  assign count_hit  = count_all_q ? (running & trg_edge) : trg_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      started_q   <= 1'b0;
      trg_q       <= 1'b0;
      count_all_q <= 1'b0;
      mode_q      <= START_SW;
      tcnt        <= '0;
    end else begin
      trg_q     <= trg_in;
      started_q <= armed_q && (mode_q == START_TRIG) && (started_q || trg_edge);
      if (ctl_wr) begin
        armed_q     <= ctl_run;
        mode_q      <= start_mode_e'(ctl_mode);
        count_all_q <= ctl_count_all;
      end
      if (clear)          tcnt <= '0;
      else if (count_hit) tcnt <= tcnt + 1'b1;
    end
  end

  // R5: acceptance only inside a live, non-full run
  p_accept_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trg_accept |-> (running && !full));

  // R5: trigger counter frozen while stopped
  p_stopped_no_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clear) |=> $stable(tcnt));

  // R4: the arming edge never becomes a trigger
  p_first_edge_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == START_TRIG && !started_q && trg_edge) |-> !trg_accept);

endmodule

// File: rtl/acq_buf_track.sv
module acq_buf_track
  import acq_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 10,
  parameter int FREE_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                ctl_wr,
  input  logic                ctl_keep_free,
  input  logic                code_wr,
  input  logic [CODE_W-1:0]   code_in,
  input  logic                free_wr,
  input  logic [FREE_W-1:0]   free_num,
  input  logic                evt_wr,
  input  logic                evt_rd,
  output logic                full,
  output logic                free_err,
  output logic [MAX_CODE:0]   occ
);

  localparam int OCC_W = MAX_CODE + 1;
  localparam int DEC_W = ((FREE_W > OCC_W) ? FREE_W : OCC_W) + 1;

  logic [CODE_W-1:0] code_q;
  logic              keep_q;
  logic [OCC_W-1:0]  blocks, limit;
  logic              inc;
  logic [DEC_W-1:0]  dec;
  logic              over;

  assign blocks = OCC_W'(blocks_of(int'(code_q), MAX_CODE));
  assign limit  = OCC_W'(full_limit(int'(blocks), keep_q));
  assign full   = (occ >= limit);
  assign inc    = evt_wr & ~full;
  assign dec    = DEC_W'(evt_rd) + (free_wr ? DEC_W'(free_num) : '0);
  assign over   = dec > DEC_W'(occ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      keep_q   <= 1'b0;
      occ      <= '0;
      free_err <= 1'b0;
    end else begin
      if (code_wr) code_q <= code_in;
      if (ctl_wr)  keep_q <= ctl_keep_free;
      if (clear) begin
        occ      <= '0;
        free_err <= 1'b0;
      end else if (over) begin
        occ      <= OCC_W'(inc);
        free_err <= 1'b1;
      end else begin
        occ <= occ + OCC_W'(inc) - OCC_W'(dec);
      end
    end
  end

  // R7: never more occupied blocks than exist
  p_occ_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= blocks);

  // R7: a write into a full buffer with nothing leaving does not grow it
  p_full_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && evt_wr && !evt_rd && !free_wr && !clear && !code_wr && !ctl_wr)
      |=> (occ == $past(occ)));

  // R12: any clear empties the buffer
  p_clear_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (occ == '0 && !free_err));

endmodule

// File: rtl/acq_run_buf_ctrl.sv
module acq_run_buf_ctrl
  import acq_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 10,
  parameter int FREE_W   = 12,
  parameter int IRQ_W    = 10,
  parameter int TCNT_W   = 16,
  localparam int OCC_W   = MAX_CODE + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_run,
  input  logic [1:0]        ctl_mode,
  input  logic              ctl_keep_free,
  input  logic              ctl_count_all,
  input  logic              bcode_wr,
  input  logic [CODE_W-1:0] bcode,
  input  logic              free_wr,
  input  logic [FREE_W-1:0] free_num,
  input  logic              sw_clear,
  input  logic [IRQ_W-1:0]  irq_level,
  input  logic              sin_lvl,
  input  logic              gpio_lvl,
  input  logic              trg_in,
  input  logic              evt_wr,
  input  logic              evt_rd,
  output logic              running,
  output logic              trg_accept,
  output logic              full,
  output logic              evt_ready,
  output logic              irq,
  output logic              free_err,
  output logic [OCC_W-1:0]  evt_stored,
  output logic [TCNT_W-1:0] trg_count
);

  localparam int CMP_W = ((IRQ_W > OCC_W) ? IRQ_W : OCC_W);

  logic run_start, trg_edge, mem_clear;

  assign mem_clear = sw_clear | bcode_wr | run_start;

  acq_run_ctrl #(.TCNT_W(TCNT_W)) u_run (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_run(ctl_run), .ctl_mode(ctl_mode),
    .ctl_count_all(ctl_count_all),
    .sin_lvl(sin_lvl), .gpio_lvl(gpio_lvl), .trg_in(trg_in),
    .full(full), .clear(mem_clear),
    .running(running), .trg_edge(trg_edge), .trg_accept(trg_accept),
    .run_start(run_start), .tcnt(trg_count)
  );

  acq_buf_track #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .FREE_W(FREE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clear(mem_clear),
    .ctl_wr(ctl_wr), .ctl_keep_free(ctl_keep_free),
    .code_wr(bcode_wr), .code_in(bcode),
    .free_wr(free_wr), .free_num(free_num),
    .evt_wr(evt_wr), .evt_rd(evt_rd),
    .full(full), .free_err(free_err), .occ(evt_stored)
  );

  assign evt_ready = (evt_stored != '0);
  assign irq       = CMP_W'(evt_stored) > CMP_W'(irq_level);

  // R10: an interrupt can only stand over a non-empty buffer
  p_irq_needs_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_ready);

  // R10: event-ready rises only after an event was written
  p_ready_from_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_ready) |-> $past(evt_wr));

endmodule

// File: tb/acq_run_buf_ctrl_tb.sv
module acq_run_buf_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        ctl_wr = 0, ctl_run = 0, ctl_keep_free = 0, ctl_count_all = 0;
  logic [1:0]  ctl_mode = 0;
  logic        bcode_wr = 0, free_wr = 0, sw_clear = 0;
  logic [3:0]  bcode = 0;
  logic [11:0] free_num = 0;
  logic [9:0]  irq_level = 0;
  logic        sin_lvl = 0, gpio_lvl = 0, trg_in = 0, evt_wr = 0, evt_rd = 0;
  logic        running, trg_accept, full, evt_ready, irq, free_err;
  logic [10:0] evt_stored;
  logic [15:0] trg_count;

  acq_run_buf_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run(ctl_run),
    .ctl_mode(ctl_mode), .ctl_keep_free(ctl_keep_free),
    .ctl_count_all(ctl_count_all), .bcode_wr(bcode_wr), .bcode(bcode),
    .free_wr(free_wr), .free_num(free_num), .sw_clear(sw_clear),
    .irq_level(irq_level), .sin_lvl(sin_lvl), .gpio_lvl(gpio_lvl),
    .trg_in(trg_in), .evt_wr(evt_wr), .evt_rd(evt_rd),
    .running(running), .trg_accept(trg_accept), .full(full),
    .evt_ready(evt_ready), .irq(irq), .free_err(free_err),
    .evt_stored(evt_stored), .trg_count(trg_count)
  );

  int n_chk = 0, n_fail = 0;

  // bench model state
  bit m_armed, m_kf, m_ca, m_started, m_trgp, m_err;
  int m_mode, m_code, m_occ;
  bit [15:0] m_tcnt;

  function automatic int nblk(int code);
    return (code >= 10) ? 1024 : (1 << code);
  endfunction

  function automatic bit m_full();
    int cap = nblk(m_code);
    if (m_kf) cap = cap - 1;
    return m_occ >= cap;
  endfunction

  function automatic bit m_run();
    if (!m_armed) return 0;
    if (m_mode == 0) return 1;
    if (m_mode == 1) return sin_lvl;
    if (m_mode == 3) return gpio_lvl;
    return m_started;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_armed = 0; m_kf = 0; m_ca = 0; m_started = 0; m_trgp = 0; m_err = 0;
    m_mode = 0; m_code = 0; m_occ = 0; m_tcnt = 0;
  endtask

  // one clock: compare all outputs with the model, then advance the model
  task automatic cyc();
    bit run, edg, fl, acc, clr, inc, hit;
    int dec;
    #1;
    run = m_run();
    edg = trg_in && !m_trgp;
    fl  = m_full();
    acc = run && edg && !fl;
    chk("R2", "running", running, run);
    chk("R5", "trg_accept", trg_accept, acc);
    chk("R7", "full", full, fl);
    chk("R10", "evt_ready", evt_ready, m_occ > 0);
    chk("R10", "irq", irq, m_occ > int'(irq_level));
    chk("R9", "evt_stored", evt_stored, m_occ);
    chk("R11", "trg_count", trg_count, m_tcnt);
    chk("R8", "free_err", free_err, m_err);
    @(posedge clk);
    clr = sw_clear || bcode_wr || (ctl_wr && ctl_run && !m_armed);
    hit = m_ca ? (run && edg) : acc;
    if (clr) m_tcnt = 0; else if (hit) m_tcnt = m_tcnt + 1;
    inc = evt_wr && !fl;
    dec = int'(evt_rd) + (free_wr ? int'(free_num) : 0);
    if (clr) begin m_occ = 0; m_err = 0; end
    else if (dec > m_occ) begin m_occ = int'(inc); m_err = 1; end
    else m_occ = m_occ + int'(inc) - dec;
    m_started = m_armed && (m_mode == 2) && (m_started || edg);
    if (ctl_wr) begin
      m_armed = ctl_run; m_mode = int'(ctl_mode); m_kf = ctl_keep_free; m_ca = ctl_count_all;
    end
    if (bcode_wr) m_code = int'(bcode);
    m_trgp = trg_in;
    @(negedge clk);
    ctl_wr = 0; bcode_wr = 0; free_wr = 0; sw_clear = 0; evt_wr = 0; evt_rd = 0;
  endtask

  task automatic ctl(bit run, int mode, bit kf, bit ca);
    ctl_wr = 1; ctl_run = run; ctl_mode = 2'(mode); ctl_keep_free = kf; ctl_count_all = ca;
    cyc();
  endtask

  task automatic pulse_trg();
    trg_in = 1; cyc(); trg_in = 0; cyc();
  endtask

  task automatic writes(int n);
    for (int i = 0; i < n; i++) begin evt_wr = 1; cyc(); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk("R1", "running", running, 0);
    chk("R1", "evt_stored", evt_stored, 0);
    chk("R1", "ready/full/irq", {evt_ready, full, irq}, 0);
    chk("R1", "trg_count", trg_count, 0);
    chk("R1", "free_err", free_err, 0);
    @(negedge clk);

    // R2: software mode
    ctl(1, 0, 0, 0);
    chk("R2", "running after run bit", running, 1);
    pulse_trg(); pulse_trg();
    chk("R2", "accepted triggers", trg_count, 2);
    bcode_wr = 1; bcode = 3; cyc();
    writes(5);
    ctl(0, 0, 0, 0);
    chk("R2", "stored kept after stop", evt_stored, 5);
    chk("R2", "running after stop", running, 0);

    // R5: stopped triggers ignored
    t0 = int'(trg_count);
    trg_in = 1; #1; chk("R5", "accept while stopped", trg_accept, 0); cyc(); trg_in = 0; cyc();
    chk("R5", "count while stopped", trg_count, t0);

    // R7: full policies
    bcode_wr = 1; bcode = 2; cyc();
    writes(5);
    chk("R7", "stored capped at 4", evt_stored, 4);
    chk("R7", "full at 4", full, 1);
    ctl(0, 0, 1, 0);
    free_wr = 1; free_num = 1; cyc();
    chk("R7", "keep-free full at 3", full, 1);

    // R8: over-release with a simultaneous write
    free_wr = 1; free_num = 5; evt_wr = 1; cyc();
    chk("R8", "over-release error", free_err, 1);
    chk("R8", "stored keeps write only", evt_stored, 0);

    // R9: write and read together
    writes(2);
    evt_wr = 1; evt_rd = 1; cyc();
    chk("R9", "write+read net", evt_stored, 2);

    // R3: level modes
    ctl(1, 1, 0, 0);
    chk("R3", "input-1 low", running, 0);
    sin_lvl = 1; cyc();
    chk("R3", "input-1 high", running, 1);
    ctl(1, 3, 0, 0);
    chk("R3", "input-2 low", running, 0);
    gpio_lvl = 1; cyc();
    chk("R3", "input-2 high", running, 1);
    sin_lvl = 0; gpio_lvl = 0; cyc();

    // R4: first-trigger mode
    ctl(0, 2, 0, 0);
    ctl(1, 2, 0, 0);
    t0 = int'(trg_count);
    trg_in = 1; #1; chk("R4", "arming edge not accepted", trg_accept, 0); cyc();
    trg_in = 0; cyc();
    chk("R4", "running after arming edge", running, 1);
    trg_in = 1; #1; chk("R4", "second edge accepted", trg_accept, 1); cyc();
    trg_in = 0; cyc();
    chk("R4", "count after second edge", trg_count, t0 + 1);
    ctl(0, 2, 0, 0);
    chk("R4", "software stop", running, 0);

    // R6: code clamp
    bcode_wr = 1; bcode = 15; cyc();
    chk("R6", "code write clears", evt_stored, 0);
    writes(1030);
    chk("R6", "clamped to 1024 blocks", evt_stored, 1024);

    // R10: interrupt level
    irq_level = 5; bcode_wr = 1; bcode = 4; cyc();
    writes(5);
    chk("R10", "irq at level", irq, 0);
    writes(1);
    chk("R10", "irq above level", irq, 1);

    // R12: software clear
    free_wr = 1; free_num = 100; cyc();
    writes(3);
    sw_clear = 1; cyc();
    chk("R12", "stored cleared", evt_stored, 0);
    chk("R12", "error cleared", free_err, 0);

    // R11: trigger while full, both counting modes
    bcode_wr = 1; bcode = 0; cyc();
    ctl(1, 0, 0, 1);
    writes(1);
    t0 = int'(trg_count);
    trg_in = 1; #1; chk("R11", "refused while full", trg_accept, 0); cyc(); trg_in = 0; cyc();
    chk("R11", "count-all counts refused", trg_count, t0 + 1);
    ctl(1, 0, 0, 0);
    pulse_trg();
    chk("R11", "accepted-only ignores refused", trg_count, t0 + 1);
    ctl(0, 0, 0, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      if (r < 3) begin
        ctl_wr = 1; ctl_run = 1'($urandom); ctl_mode = 2'($urandom);
        ctl_keep_free = 1'($urandom); ctl_count_all = 1'($urandom);
      end else if (r < 5) begin
        bcode_wr = 1; bcode = 4'($urandom % 6);
      end else if (r < 11) begin
        free_wr = 1; free_num = 12'($urandom % 8);
      end else if (r == 11) sw_clear = 1;
      evt_wr = 1'($urandom);
      evt_rd = ($urandom % 6) == 0;
      if ($urandom % 3 == 0) trg_in = ~trg_in;
      if ($urandom % 20 == 0) sin_lvl = ~sin_lvl;
      if ($urandom % 20 == 0) gpio_lvl = ~gpio_lvl;
      if ($urandom % 50 == 0) irq_level = 10'($urandom % 40);
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule